// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive approximation analog-to-digital conversion. A start request is accepted only while the block is idle. It then raises a hold strobe so that an external sample/hold circuit freezes the input. After that it walks through the bits from the most significant to the least significant. For each bit it drives a trial code to an external DAC, waits one clock for the analog path to settle, and samples a single comparator bit. That bit says whether the held input is at or above the trial threshold. The block keeps the trial bit when the comparator says so and clears it otherwise.

The search runs in offset-binary space. A trial code `n` places its threshold at `(n - 2^(W-1) - 1/2)` LSB, so the result is rounded to the nearest code, with ties going up, and it saturates at both ends. At the end, the top bit of the offset-binary code is inverted to give a two's complement result. The result is presented together with a one-cycle done pulse.

The DAC, the comparator and the sample/hold are outside the block. The control pins are plain level or pulse signals with no back-pressure. The result is not a stream: it simply stays on its port until the next conversion completes, so a consumer that misses the done pulse can still read it.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `hold_o`, `done_o`, `dac_o` and `result_o` are all zero.
- R2: A start request sampled while idle raises `hold_o` in the next cycle. `hold_o` then stays high for exactly 2*W+1 cycles and falls in the cycle in which `done_o` is high.
- R3: Trials run MSB first. The first trial code is `1 << (W-1)`. Trial k holds the bits already decided, a 1 at bit position W-1-k, and zeros below it. Each trial code is held on `dac_o` for two cycles.
- R4: `cmp_i` is sampled at the end of the second cycle of each trial. A value of 1 (input at or above the threshold) keeps the trial bit, and 0 clears it.
- R5: `result_o` is the final offset-binary code with its top bit inverted. As a signed value this equals round-to-nearest of the input in LSB units, with ties rounding up, saturated to the range [-2^(W-1), 2^(W-1)-1].
- R6: `done_o` is high for exactly one cycle per conversion, and `result_o` already holds the new value in that cycle.
- R7: A start request while `hold_o` is high is ignored. It changes neither the trial sequence, nor the timing, nor the result.
- R8: `result_o` keeps its value, whatever the comparator does, until the next conversion's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, acted on only when idle |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the trial threshold |
| dac_o | output | W | Trial code to the external DAC (offset binary) |
| hold_o | output | 1 | Sample/hold strobe, high for the whole conversion |
| result_o | output | W | Two's complement conversion result |
| done_o | output | 1 | One-cycle pulse when a new result is available |

## Verification
A wrong bit index or a corrupted trial register shows on `dac_o` within two cycles of the fault, as a trial code that departs from the MSB-first pattern. It would also spread into a result that is off by a power of two. A state machine that skips or repeats a step shifts the done pulse and the fall of `hold_o` away from the fixed 2*W+1 cycle window, so it is seen at the end of the same conversion. A start accepted by mistake, or a result register written outside the done cycle, becomes visible as a changed result or a broken hold window within one conversion.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  // Sequencer phases of one conversion
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // waiting for a start request
    PH_SAMPLE = 2'd1,  // hold asserted, input being frozen
    PH_SET    = 2'd2,  // new trial code on the DAC, settling
    PH_CMP    = 2'd3   // comparator sampled at end of this cycle
  } sar_phase_t;

  // Width of a bit index for a conversion of w bits
  function automatic int idx_width(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_ctrl_pkg::*;
#(
  parameter int W = 4,
  localparam int IW = idx_width(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output sar_phase_t    phase_o,
  output logic [IW-1:0] idx_o,
  output logic          init_o,
  output logic          decide_o,
  output logic          finish_o,
  output logic          hold_o,
  output logic          done_o
);

  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  sar_phase_t    phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          hold_q, hold_d;
  logic          done_q, done_d;
  logic          last_bit;

  assign last_bit = (idx_q == '0);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    hold_d  = hold_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_SAMPLE;
          hold_d  = 1'b1;
        end
      end
      PH_SAMPLE: begin
        phase_d = PH_SET;
        idx_d   = TOP_IDX;
      end
      PH_SET: begin
        phase_d = PH_CMP;
      end
      PH_CMP: begin
        if (last_bit) begin
          phase_d = PH_IDLE;
          hold_d  = 1'b0;
          done_d  = 1'b1;
        end else begin
          phase_d = PH_SET;
          idx_d   = idx_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      hold_q  <= hold_d;
      done_q  <= done_d;
    end
  end

  assign phase_o  = phase_q;
  assign idx_o    = idx_q;
  assign init_o   = (phase_q == PH_SAMPLE);
  assign decide_o = (phase_q == PH_CMP);
  assign finish_o = decide_o && last_bit;
  assign hold_o   = hold_q;
  assign done_o   = done_q;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_ctrl_pkg::*;
#(
  parameter int W = 4,
  localparam int IW = idx_width(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          decide_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [W-1:0]  code_o,
  output logic [W-1:0]  code_next_o
);

  logic [W-1:0] code_q;
  logic [W-1:0] code_d;

  // One slice per bit: seed, decide, or arm as the next trial
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic is_cur;
    logic is_nxt;
    assign is_cur = (int'(idx_i) == b);
    assign is_nxt = (int'(idx_i) == b + 1);

    always_comb begin
      code_d[b] = code_q[b];
      if (init_i) begin
        code_d[b] = (b == W - 1);
      end else if (decide_i) begin
        if (is_cur)      code_d[b] = cmp_i;
        else if (is_nxt) code_d[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o      = code_q;
  assign code_next_o = code_d;

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] offset_code_i,
  output logic [W-1:0] result_o
);

  logic [W-1:0] twos;
  logic [W-1:0] result_q;

  // Offset binary to two's complement: flip the sign position only
  assign twos = offset_code_i ^ {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n)      result_q <= '0;
    else if (load_i) result_q <= twos;
  end

  assign result_o = result_q;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_o,
  output logic         hold_o,
  output logic [W-1:0] result_o,
  output logic         done_o
);

  localparam int IW = idx_width(W);

  sar_phase_t    phase;
  logic [IW-1:0] idx;
  logic          init;
  logic          decide;
  logic          finish;
  logic [W-1:0]  code_next;

  sar_seq_fsm #(.W(W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .phase_o  (phase),
    .idx_o    (idx),
    .init_o   (init),
    .decide_o (decide),
    .finish_o (finish),
    .hold_o   (hold_o),
    .done_o   (done_o)
  );

  sar_trial_reg #(.W(W)) trial_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init),
    .decide_i    (decide),
    .idx_i       (idx),
    .cmp_i       (cmp_i),
    .code_o      (dac_o),
    .code_next_o (code_next)
  );

  sar_result_fmt #(.W(W)) fmt_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (finish),
    .offset_code_i (code_next),
    .result_o      (result_o)
  );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] dac_o,
  input logic         hold_o,
  input logic [W-1:0] result_o,
  input logic         done_o
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done wider than one cycle"); // R6

  AST_HOLD_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> done_o) else $error("hold fell without done"); // R2

  AST_DONE_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !hold_o) else $error("hold high during done"); // R2

  AST_TRIAL_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !$stable(dac_o)) |=> $stable(dac_o)) else $error("trial code held one cycle"); // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)) else $error("result moved without done"); // R8

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && start_i && !$rose(hold_o)) |=> (hold_o || done_o)) else $error("busy start disturbed run"); // R7

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .dac_o    (dac_o),
  .hold_o   (hold_o),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;

  localparam int W = 4;
  localparam int H = 1 << (W - 1);
  localparam int SPAN = 2 * W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp;
  logic [W-1:0] dac;
  logic         hold;
  logic [W-1:0] result;
  logic         done;

  int vin_q = 0;  // held input in quarter-LSB units
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // Ideal analog model: threshold of code n sits at (n - H - 1/2) LSB
  assign cmp = (vin_q >= 4 * (int'(dac) - H) - 2);

  sar_adc_ctrl #(.W(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .cmp_i    (cmp),
    .dac_o    (dac),
    .hold_o   (hold),
    .result_o (result),
    .done_o   (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Rounded, saturated expectation from the requirement
  function automatic int exp_round(input int vq);
    int r;
    r = (vq + 2) >>> 2;
    if (r < -H) r = -H;
    if (r > H - 1) r = H - 1;
    return r;
  endfunction

  // Trial code k of an MSB-first search for input vq
  function automatic int exp_trial(input int vq, input int k);
    int code = 0;
    int t = 0;
    for (int j = 0; j <= k; j++) begin
      t = code | (1 << (W - 1 - j));
      if (j < k && vq >= 4 * (t - H) - 2) code = t;
    end
    return t;
  endfunction

  task automatic run_conv(input int vq, input bit poke);
    int er;
    er = exp_round(vq);
    vin_q = vq;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(hold === 1'b1, "R2 hold after start", int'(hold), 1);
    for (int c = 1; c < SPAN; c++) begin
      @(negedge clk);
      start = poke && (c == 3 || c == SPAN - 1);
      check(int'(dac) == exp_trial(vq, (c - 1) / 2), "R3 R4 trial code", int'(dac), exp_trial(vq, (c - 1) / 2));
      check(hold === 1'b1 && done === 1'b0, "R2 hold window", int'({hold, done}), 2);
    end
    @(negedge clk) start = 1'b0;
    check(done === 1'b1, "R6 done pulse", int'(done), 1);
    check(hold === 1'b0, "R2 hold drops with done", int'(hold), 0);
    check(int'($signed(result)) == er, poke ? "R7 R5 result with busy start" : "R5 result", int'($signed(result)), er);
    @(negedge clk);
    check(done === 1'b0 && hold === 1'b0, "R6 R7 single done, no restart", int'({hold, done}), 0);
    vin_q = -vq + 5;
    repeat (3) @(negedge clk);
    check(int'($signed(result)) == er, "R8 result held", int'($signed(result)), er);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(hold === 1'b0 && done === 1'b0, "R1 reset controls", int'({hold, done}), 0);
    check(dac === '0 && result === '0, "R1 reset data", int'({dac, result}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(hold === 1'b0, "R1 idle without start", int'(hold), 0);
    // Directed corners
    run_conv(-9, 1'b0);            // -2.25 LSB -> 1110 (R5)
    check(result === 4'b1110, "R5 worked pattern", int'(result), 14);
    run_conv(2, 1'b0);             // +0.5 LSB tie rounds up (R4)
    run_conv(-2, 1'b0);            // -0.5 LSB tie rounds up to 0 (R4)
    run_conv(-200, 1'b0);          // saturate low (R5)
    run_conv(200, 1'b0);           // saturate high (R5)
    run_conv(4 * (H - 1), 1'b1);   // full scale with busy starts (R7)
    process::self().srandom(32'd1234);
    for (int n = 0; n < 40; n++) begin
      int v;
      v = int'($urandom_range(8 * H + 12)) - (4 * H + 6);
      run_conv(v, ($urandom_range(3) == 0));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule